// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This block drives a set of pulse-width-modulated output pins from a single time base. A shared 8-bit prescaler divides the input clock into ticks, a shared 8-bit counter runs through 256 ticks per period, and each channel compares that counter against its own duty value. One enable bit starts and stops every channel together. The only period control is the prescaler, so the period is always 256 × (prescale + 1) clock cycles.

Software reaches the block through a plain 32-bit word write/read port. Each channel has a duty register, and the block also has one control register and one interrupt-enable register. Duty and prescaler writes made while the block runs are held back until the next period boundary, so a running output never shows a cut-short or doubled pulse. A duty value of 0 still gives a one-tick pulse, and a duty value of 255 keeps the output high for the whole period.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output pin is low and every mapped register reads back zero.
- R2: The duty register of channel i sits at byte offset 4·i and holds 8 bits in bits 7:0. Its upper bits read zero. Offsets of channels at or beyond CHANNELS, and any offset that is not mapped, read back zero.
- R3: The control register at offset 0x50 holds prescaler bits 3:0 in register bits 3:0, prescaler bits 7:4 in register bits 14:11, and the global enable in bit 9. Every other bit reads zero.
- R4: The interrupt-enable register at offset 0x54 stores bit 0 and reads it back. Its other bits read zero. It has no effect on the outputs.
- R5: While the enable is 0, every output is low and the time base is held at the start of a period.
- R6: Once enabled, a period lasts exactly 256·(p+1) clock cycles, where p is the prescaler. Channel output is high for the first (d+1)·(p+1) cycles of each period, where d is the duty value, starting in the first cycle after the enabling write.
- R7: Duty 0 gives a pulse exactly p+1 cycles long. Duty 255 keeps the output high for the entire period.
- R8: All channels share one period start. Each channel's pulse width follows only its own duty value.
- R9: A duty write made while running changes nothing in the current period. It applies from the next period boundary.
- R10: A prescaler write made while running applies from the next period boundary. The first period after enabling uses the prescaler stored before the enabling write, so a prescaler carried in the enabling write itself applies from the first boundary.
- R11: Clearing and then setting the enable restarts the waveform from the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte address for the register port, used for both writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, returned in the same cycle |
| pwm_out | output | CHANNELS | One PWM output per channel |

## Verification
On every cycle the assertions check four things. The outputs stay low while the enable is clear. The tick divider never passes the active prescale. The counter moves only on a tick, and a channel with an active counter at zero is always high. The active duty and prescaler change only at a period boundary or while the block is stopped. The exact pulse widths and period lengths for every duty value are shown only by the bench's arithmetic sweeps, and so is the one-period delay before a running write takes effect. The same holds for the field positions of the control register, the read-back masking and the restart after a disable.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
   localparam int TICK_W       = 8;    // counter width: 256 ticks per period
   localparam int PRE_W        = 8;    // prescaler width
   localparam int NIB_W        = 4;    // width of each prescaler field
   localparam int PRE_LO_LSB   = 0;    // control bits 3:0
   localparam int PRE_HI_LSB   = 11;   // control bits 14:11
   localparam int RUN_BIT      = 9;    // global enable
   localparam int CTRL_WORD    = 20;   // byte offset 0x50
   localparam int IRQ_WORD     = 21;   // byte offset 0x54
   localparam int MAX_CHANNELS = CTRL_WORD;
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
   import pwm_bank_pkg::*;
#(
   parameter int CHANNELS = 1,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int DUTY_W   = TICK_W,
   parameter int PSC_W    = PRE_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [CHANNELS*DUTY_W-1:0] duty_flat,
   output logic [PSC_W-1:0]           psc_q,
   output logic                       run_q,
   output logic                       irq_en_q
);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(CTRL_WORD);
   localparam logic [IDX_W-1:0] IRQ_IDX  = IDX_W'(IRQ_WORD);

   logic [IDX_W-1:0]  word_idx;
   logic [DUTY_W-1:0] duty_r [CHANNELS];

   assign word_idx = addr[ADDR_W-1:2];

   for (genvar i = 0; i < CHANNELS; i++) begin : g_duty
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            duty_r[i] <= '0;
         else if (wr_en && word_idx == IDX_W'(i))
            duty_r[i] <= wdata[DUTY_W-1:0];
      end
      assign duty_flat[i*DUTY_W +: DUTY_W] = duty_r[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q    <= '0;
         run_q    <= 1'b0;
         irq_en_q <= 1'b0;
      end else if (wr_en) begin
         if (word_idx == CTRL_IDX) begin
            psc_q[NIB_W-1:0]     <= wdata[PRE_LO_LSB +: NIB_W];
            psc_q[PSC_W-1:NIB_W] <= wdata[PRE_HI_LSB +: NIB_W];
            run_q                <= wdata[RUN_BIT];
         end
         if (word_idx == IRQ_IDX)
            irq_en_q <= wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (word_idx == CTRL_IDX) begin
         rdata[PRE_LO_LSB +: NIB_W] = psc_q[NIB_W-1:0];
         rdata[PRE_HI_LSB +: NIB_W] = psc_q[PSC_W-1:NIB_W];
         rdata[RUN_BIT]             = run_q;
      end else if (word_idx == IRQ_IDX) begin
         rdata[0] = irq_en_q;
      end else begin
         for (int i = 0; i < CHANNELS; i++)
            if (word_idx == IDX_W'(i))
               rdata[DUTY_W-1:0] = duty_r[i];
      end
   end

   // R4: the stored interrupt enable changes only through a write to its word
   a_r4_irq_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && word_idx == IRQ_IDX) |=> $stable(irq_en_q));
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W = TICK_W,
   parameter int PSC_W = PRE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] psc_reg,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap,
   output logic             load
);
   logic [PSC_W-1:0] psc_act;
   logic [PSC_W-1:0] div_q;
   logic             tick;

   assign tick = run && (div_q == psc_act);
   assign wrap = tick && (cnt_q == {CNT_W{1'b1}});
   assign load = !run || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         cnt_q   <= '0;
         psc_act <= '0;
      end else begin
         if (!run) begin
            div_q <= '0;
            cnt_q <= '0;
         end else if (tick) begin
            div_q <= '0;
            cnt_q <= cnt_q + 1'b1;
         end else begin
            div_q <= div_q + 1'b1;
         end
         if (load)
            psc_act <= psc_reg;
      end
   end

   // R6: the divider never runs past the active prescale
   a_r6_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (div_q <= psc_act));
   // R6: the period counter moves only on a prescaled tick
   a_r6_cnt_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> (cnt_q == $past(cnt_q)));
   // R10: the active prescale is frozen inside a running period
   a_r10_psc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(psc_act));
   // R5: a stopped time base sits at the period start
   a_r5_held_start: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0 && div_q == '0));
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W = TICK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] duty_shadow,
   input  logic [CNT_W-1:0] cnt,
   output logic             pwm
);
   logic [CNT_W-1:0] duty_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         duty_act <= '0;
      else if (load)
         duty_act <= duty_shadow;
   end

   assign pwm = run && (cnt <= duty_act);

   // R9: the duty in force changes only at a boundary or while stopped
   a_r9_duty_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(duty_act));
   // R7: every period opens with the output high, even for duty 0
   a_r7_first_tick_high: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt == '0) |-> pwm);
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int CHANNELS = 1,
   parameter int ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic [CHANNELS-1:0] pwm_out
);
   localparam int DATA_W = 32;
   localparam int CNT_W  = TICK_W;
   localparam int PSC_W  = PRE_W;

   if (CHANNELS < 1 || CHANNELS > MAX_CHANNELS) begin : g_bad_channels
      $error("pwm_bank: CHANNELS must lie in 1..%0d", MAX_CHANNELS);
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("pwm_bank: ADDR_W too narrow to reach the control word");
   end
   if (PSC_W != 2 * NIB_W) begin : g_bad_psc
      $error("pwm_bank: prescaler must fill both control fields");
   end

   logic [CHANNELS*CNT_W-1:0] duty_flat;
   logic [PSC_W-1:0]          psc_q;
   logic                      run_q;
   logic                      irq_en_q;
   logic [CNT_W-1:0]          cnt;
   logic                      wrap;
   logic                      load;

   pwm_regs #(
      .CHANNELS(CHANNELS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DUTY_W(CNT_W), .PSC_W(PSC_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .duty_flat(duty_flat),
      .psc_q(psc_q), .run_q(run_q), .irq_en_q(irq_en_q)
   );

   pwm_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_timebase (
      .clk(clk), .rst_n(rst_n), .run(run_q), .psc_reg(psc_q),
      .cnt_q(cnt), .wrap(wrap), .load(load)
   );

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      pwm_chan #(.CNT_W(CNT_W)) i_chan (
         .clk(clk), .rst_n(rst_n), .run(run_q), .load(load),
         .duty_shadow(duty_flat[c*CNT_W +: CNT_W]), .cnt(cnt),
         .pwm(pwm_out[c])
      );
   end

   // R5: no channel drives high while the global enable is clear
   a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (pwm_out == '0));
   // R8: the counter only wraps while running
   a_r8_wrap_running: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> run_q);
endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
   localparam int NCH = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH-1:0] pwm_out;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pwm_bank #(.CHANNELS(NCH), .ADDR_W(8)) i_pwm_bank (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl_word(input int p, input bit en);
      return (32'(p >> 4) << 11) | (32'(en) << 9) | 32'(p & 15);
   endfunction

   function automatic bit exp_out(input int k, input int p, input int d);
      return ((k / (p + 1)) % 256) <= d;
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic start(input int p, input int d0, input int d1, input int d2);
      wr(8'h50, ctrl_word(p, 1'b0));
      wr(8'h00, 32'(d0));
      wr(8'h04, 32'(d1));
      wr(8'h08, 32'(d2));
      wr(8'h50, ctrl_word(p, 1'b1));
   endtask

   // Sample one full period from the first cycle after the enabling write.
   task automatic run_period(input string req, input int p, input int d0, input int d1, input int d2);
      int d [NCH];
      int mism [NCH];
      int hi [NCH];
      d[0] = d0; d[1] = d1; d[2] = d2;
      for (int c = 0; c < NCH; c++) begin mism[c] = 0; hi[c] = 0; end
      for (int k = 0; k < 256 * (p + 1); k++) begin
         for (int c = 0; c < NCH; c++) begin
            if (pwm_out[c] !== exp_out(k, p, d[c])) mism[c]++;
            if (pwm_out[c] === 1'b1) hi[c]++;
         end
         @(negedge clk);
      end
      for (int c = 0; c < NCH; c++) begin
         chk({req, (c == 0) ? " R6 waveform" : " R8 waveform"}, 32'(mism[c]), 32'd0);
         chk({req, (d[c] == 0 || d[c] == 255) ? " R7 high time" : " R6 high time"},
             32'(hi[c]), 32'((d[c] + 1) * (p + 1)));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int mism;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 outputs", 32'(pwm_out), 32'd0);
      rd_chk("R1 duty0", 8'h00, 32'd0);
      rd_chk("R1 duty2", 8'h08, 32'd0);
      rd_chk("R1 ctrl", 8'h50, 32'd0);
      rd_chk("R1 irq", 8'h54, 32'd0);

      // R2: duty map and masking
      wr(8'h04, 32'hFFFF_FFA5);
      rd_chk("R2 duty1 readback", 8'h04, 32'h0000_00A5);
      rd_chk("R2 duty0 untouched", 8'h00, 32'd0);
      wr(8'h0C, 32'h0000_0077);
      rd_chk("R2 absent channel", 8'h0C, 32'd0);
      wr(8'h40, 32'hFFFF_FFFF);
      rd_chk("R2 unmapped", 8'h40, 32'd0);

      // R4: interrupt enable stores bit 0 only, no effect on outputs
      wr(8'h54, 32'hFFFF_FFFF);
      rd_chk("R4 irq readback", 8'h54, 32'd1);
      chk("R4 outputs unaffected", 32'(pwm_out), 32'd0);

      // R3: control field positions, enable at bit 9
      wr(8'h50, 32'hFFFF_FFFF);
      rd_chk("R3 ctrl readback", 8'h50, 32'h0000_7A0F);
      wr(8'h50, 32'h0000_0000);
      @(negedge clk);
      rd_chk("R3 ctrl cleared", 8'h50, 32'd0);
      chk("R5 outputs after disable", 32'(pwm_out), 32'd0);

      // R6 R7 R8: sweep every duty value with prescale 0
      for (int dv = 0; dv < 256; dv++) begin
         start(0, dv, 255 - dv, (dv * 7) % 256);
         run_period("sweep", 0, dv, 255 - dv, (dv * 7) % 256);
      end

      // R3 R6: prescaler values exercising both fields
      begin
         int plist [5] = '{1, 3, 15, 16, 37};
         foreach (plist[i]) begin
            start(plist[i], (plist[i] * 3) % 256, 0, 255);
            run_period("prescale", plist[i], (plist[i] * 3) % 256, 0, 255);
         end
      end

      // R5: stop mid-period, outputs low for a while
      start(0, 200, 200, 200);
      repeat (77) @(negedge clk);
      wr(8'h50, ctrl_word(0, 1'b0));
      mism = 0;
      for (int k = 0; k < 30; k++) begin
         if (pwm_out !== '0) mism++;
         @(negedge clk);
      end
      chk("R5 low while disabled", 32'(mism), 32'd0);

      // R11: re-enable restarts the waveform from period start
      wr(8'h50, ctrl_word(0, 1'b1));
      run_period("R11 restart", 0, 200, 200, 200);

      // R9: duty write mid-period applies at next boundary
      start(0, 50, 10, 0);
      mism = 0;
      for (int k = 0; k < 512; k++) begin
         if (pwm_out[0] !== exp_out(k % 256, 0, (k < 256) ? 50 : 200)) mism++;
         if (pwm_out[1] !== exp_out(k % 256, 0, 10)) mism++;
         if (k == 100) begin reg_wr = 1'b1; reg_addr = 8'h00; reg_wdata = 32'd200; end
         if (k == 101) reg_wr = 1'b0;
         @(negedge clk);
      end
      chk("R9 deferred duty", 32'(mism), 32'd0);

      // R10: prescaler write mid-period applies at next boundary
      start(1, 100, 100, 100);
      mism = 0;
      for (int k = 0; k < 512 + 1024; k++) begin
         if (k < 512) begin
            if (pwm_out[0] !== exp_out(k, 1, 100)) mism++;
         end else begin
            if (pwm_out[0] !== exp_out(k - 512, 3, 100)) mism++;
         end
         if (k == 300) begin reg_wr = 1'b1; reg_addr = 8'h50; reg_wdata = ctrl_word(3, 1'b1); end
         if (k == 301) reg_wr = 1'b0;
         @(negedge clk);
      end
      chk("R10 deferred prescale", 32'(mism), 32'd0);

      // R10: prescaler carried in the enabling write applies from the first boundary
      wr(8'h50, ctrl_word(0, 1'b0));
      wr(8'h50, ctrl_word(1, 1'b1));
      mism = 0;
      for (int k = 0; k < 256 + 512; k++) begin
         if (k < 256) begin
            if (pwm_out[0] !== exp_out(k, 0, 100)) mism++;
         end else begin
            if (pwm_out[0] !== exp_out(k - 256, 1, 100)) mism++;
         end
         @(negedge clk);
      end
      chk("R10 enable-write prescale", 32'(mism), 32'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule